// File: doc/BRIEF.md
# High-Speed Serial Port with Register Bus

This block is a serial port for 8-bit characters with one start bit, one stop bit and no parity. Software talks to it over a 32-bit register bus with single-cycle writes and combinational reads. Characters written to the data register go into a 64-entry transmit queue. The transmitter drains the queue onto the serial output, least significant bit first. Every bit lasts (rate+1)*14 clock cycles.

The receiver runs 14 sub-bit ticks per bit. It detects a start bit on a falling edge of the input and samples each bit near its middle. It then puts each character, with its framing-error and break flags, into a 64-entry receive queue. Reading the data register removes the oldest entry. Latched event bits are collected in a status register and cleared by writing ones. Three enable groups in the control register steer them to a single interrupt line.

Top module: `hsu_uart`

## Requirements
- R1: After reset the rate register (word 0x10) reads 0xFF, the control (0x0C), level (0x04) and status (0x08) registers read 0, the data register (0x00) reads 0x100, the serial output is high and the interrupt is low.
- R2: A character is sent as a low start bit, eight data bits LSB first and a high stop bit, each bit lasting (rate+1)*14 clocks. When the transmitter is idle, a frame starts in the cycle after the write to the data register. Queued frames are separated by one idle clock.
- R3: The transmit queue holds 64 characters, and its occupancy is reported in level bits [15:8]. A data write while the queue is full is ignored.
- R4: A read of word 0x00 returns the oldest received character in bits [7:0] and removes it. When the queue is empty the read returns 0x100 (bit 8 = empty) and removes nothing. The receive occupancy is reported in level bits [7:0].
- R5: A character whose stop bit samples low sets bit 9 of its data word and sets status bit 3.
- R6: A character with all data bits zero and a low stop bit also sets bit 10 of its data word and status bit 4.
- R7: A character that completes while the receive queue holds 64 entries is dropped and sets status bit 5.
- R8: Control bits [4:2] select a receive trigger of 1, 4, 8, 16, 32 or 48 characters for codes 0 to 5. Status bit 1 is set when a received character raises the occupancy to that level.
- R9: Control bits [1:0] select a transmit level of 0, 4, 8 or 16. Status bit 0 is set when the transmitter takes a character and leaves the occupancy at or below that level. Writing 1 to status bit 6 also sets status bit 0.
- R10: Control bits [17:16] select a receive timeout of off, 4, 8 or 16 character times (10 bits each). Status bit 2 is set once the receive queue has stayed non-empty, with the receiver idle and no data read, for that long.
- R11: Writing a 1 to a status bit in [5:0] clears it. Bits written with 0 keep their value.
- R12: The interrupt is high when status bit 0 is set with control bit 5, when status bit 1 or 2 is set with control bit 6, or when any of status bits 3 to 5 is set with control bit 7.
- R13: Control bit 8 holds the serial output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at word 0x00) |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| irq | output | 1 | Interrupt request |

## Verification
A wrong transmit pointer, count or bit counter shows up on the serial output within one bit period, and the bench compares that output with its own queue-based model on every clock. Receive-side faults reach the ports at the next data or level read. Loopback runs of 65 characters make a bad queue depth or overrun decision visible as a wrong level, a missing status bit 5 or an out-of-order character. Status faults become visible on the interrupt line as soon as the matching enable group is switched on.

// File: rtl/hsu_uart.sv
module hsu_uart #(
  parameter int DEPTH = 64,
  parameter int OVS   = 14,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          txd,
  input  logic          rxd,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int BW = $clog2(256 * OVS) + 1;
  localparam int SW = $clog2(OVS);

  logic [7:0]  rate;
  logic [17:0] ctrl;
  logic [5:0]  st;
  logic [BW-1:0] bit_len;
  logic [AW-3:0] widx;
  logic unused_bits;

  assign widx = bus_addr[AW-1:2];
  assign bit_len = BW'((32'(rate) + 32'd1) * 32'(OVS));
  assign unused_bits = ^{bus_wdata[31:18], bus_addr[1:0]};

  logic wr_data, wr_st, wr_ctl, wr_rate;
  assign wr_data = bus_wr && widx == 0;
  assign wr_st   = bus_wr && widx == 2;
  assign wr_ctl  = bus_wr && widx == 3;
  assign wr_rate = bus_wr && widx == 4;

  // transmit queue and shifter
  logic [7:0]    tx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt, tx_lvl;
  logic          tx_busy, tx_push, tx_pop, tx_req_set;
  logic [9:0]    tx_sh;
  logic [3:0]    tx_bit;
  logic [BW-1:0] tx_tc;

  assign tx_push = wr_data && tx_cnt != CW'(DEPTH);
  assign tx_pop  = !tx_busy && tx_cnt != 0;

  always_comb
    case (ctrl[1:0])
      2'd0: tx_lvl = CW'(0);
      2'd1: tx_lvl = CW'(4);
      2'd2: tx_lvl = CW'(8);
      default: tx_lvl = CW'(16);
    endcase
  assign tx_req_set = tx_pop && !tx_push && tx_cnt <= tx_lvl + CW'(1);

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_bit <= '0; tx_tc <= '0;
    end else if (tx_pop) begin
      tx_busy <= 1'b1; tx_sh <= {1'b1, tx_mem[tx_rp], 1'b0};
      tx_bit <= '0; tx_tc <= '0;
    end else if (tx_busy) begin
      if (tx_tc == bit_len - 1'b1) begin
        tx_tc <= '0;
        if (tx_bit == 4'd9) tx_busy <= 1'b0;
        else begin
          tx_sh  <= {1'b1, tx_sh[9:1]};
          tx_bit <= tx_bit + 1'b1;
        end
      end else tx_tc <= tx_tc + 1'b1;
    end

  assign txd = !ctrl[8] && (!tx_busy || tx_sh[0]);

  // receiver
  logic [2:0]    rx_q;
  logic          rx_cur, rx_fall, rx_busy, rx_tick, rx_mid, rx_done;
  logic [7:0]    rx_pre, rx_sh;
  logic [SW-1:0] rx_smp;
  logic [3:0]    rx_bit;
  logic          fe_ev, brk_ev, ovf_ev, rx_push, rd_pop, rx_trig_set;
  logic [9:0]    rx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt, rx_lvl;

  assign rx_cur  = rx_q[1];
  assign rx_fall = rx_q[2] && !rx_q[1];
  assign rx_tick = rx_pre == rate;
  assign rx_mid  = rx_busy && rx_tick && rx_smp == SW'(OVS / 2 - 1);
  assign rx_done = rx_mid && rx_bit == 4'd9;
  assign fe_ev   = rx_done && !rx_cur;
  assign brk_ev  = fe_ev && rx_sh == 8'd0;
  assign rx_push = rx_done && rx_cnt != CW'(DEPTH);
  assign ovf_ev  = rx_done && rx_cnt == CW'(DEPTH);
  assign rd_pop  = bus_rd && widx == 0 && rx_cnt != 0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_q <= '1;
    else        rx_q <= {rx_q[1:0], rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_pre <= '0; rx_smp <= '0; rx_bit <= '0; rx_sh <= '0;
    end else if (!rx_busy) begin
      if (rx_fall) begin
        rx_busy <= 1'b1; rx_pre <= '0; rx_smp <= '0; rx_bit <= '0;
      end
    end else begin
      rx_pre <= rx_tick ? '0 : rx_pre + 1'b1;
      if (rx_tick) begin
        if (rx_smp == SW'(OVS - 1)) begin
          rx_smp <= '0;
          rx_bit <= rx_bit + 1'b1;
        end else rx_smp <= rx_smp + 1'b1;
      end
      if (rx_mid) begin
        if (rx_bit == 4'd0 && rx_cur) rx_busy <= 1'b0;
        else if (rx_bit == 4'd9)      rx_busy <= 1'b0;
        else if (rx_bit != 4'd0)      rx_sh <= {rx_cur, rx_sh[7:1]};
      end
    end

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= {brk_ev, fe_ev, rx_sh};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rd_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rd_pop);
    end

  always_comb
    case (ctrl[4:2])
      3'd0: rx_lvl = CW'(1);
      3'd1: rx_lvl = CW'(4);
      3'd2: rx_lvl = CW'(8);
      3'd3: rx_lvl = CW'(16);
      3'd4: rx_lvl = CW'(32);
      default: rx_lvl = CW'(48);
    endcase
  assign rx_trig_set = rx_push && !rd_pop && rx_cnt == rx_lvl - CW'(1);

  // inactivity timeout, counted in bit periods
  logic [BW-1:0] tmo_tc;
  logic [7:0]    tmo_bits, tmo_lim;
  logic          tmo_run, tmo_step, tmo_fire;

  always_comb
    case (ctrl[17:16])
      2'd1: tmo_lim = 8'd40;
      2'd2: tmo_lim = 8'd80;
      default: tmo_lim = 8'd160;
    endcase
  assign tmo_run  = ctrl[17:16] != 2'd0 && rx_cnt != 0 && !rx_busy && !rd_pop;
  assign tmo_step = tmo_run && tmo_bits != tmo_lim && tmo_tc == bit_len - 1'b1;
  assign tmo_fire = tmo_step && tmo_bits == tmo_lim - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmo_tc <= '0; tmo_bits <= '0;
    end else if (!tmo_run) begin
      tmo_tc <= '0; tmo_bits <= '0;
    end else if (tmo_step) begin
      tmo_tc <= '0; tmo_bits <= tmo_bits + 1'b1;
    end else if (tmo_bits != tmo_lim) tmo_tc <= tmo_tc + 1'b1;

  // registers
  logic [5:0] st_set, st_clr;
  assign st_set = {ovf_ev, brk_ev, fe_ev, tmo_fire, rx_trig_set,
                   tx_req_set || (wr_st && bus_wdata[6])};
  assign st_clr = wr_st ? bus_wdata[5:0] : 6'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rate <= 8'hFF; ctrl <= '0; st <= '0;
    end else begin
      if (wr_rate) rate <= bus_wdata[7:0];
      if (wr_ctl)  ctrl <= bus_wdata[17:0];
      st <= (st & ~st_clr) | st_set;
    end

  assign irq = (st[0] && ctrl[5]) || ((st[1] || st[2]) && ctrl[6]) ||
               ((|st[5:3]) && ctrl[7]);

  always_comb
    case (widx)
      3'd0: bus_rdata = (rx_cnt == 0) ? 32'h100 :
                        {21'd0, rx_mem[rx_rp][9:8], 1'b0, rx_mem[rx_rp][7:0]};
      3'd1: bus_rdata = {16'd0, 8'(tx_cnt), 8'(rx_cnt)};
      3'd2: bus_rdata = {26'd0, st};
      3'd3: bus_rdata = {14'd0, ctrl};
      3'd4: bus_rdata = {24'd0, rate};
      default: bus_rdata = 32'd0;
    endcase

  a_r3_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data && tx_cnt == CW'(DEPTH) && tx_busy |=> tx_cnt == CW'(DEPTH));
  a_r3_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  a_r4_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop && !rx_push |=> rx_cnt == $past(rx_cnt) - CW'(1));
  a_r6_break_is_framing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[4]) |-> st[3]);
  a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_cnt == CW'(DEPTH) |=> st[5]);
  a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st && bus_wdata[3] && !fe_ev |=> !st[3]);
endmodule

// File: tb/hsu_uart_tb.sv
module hsu_uart_tb;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic txd, rxd, irq;
  logic lb = 0, rx_drv = 1;
  int errs = 0, checks = 0;
  logic [31:0] v;

  always #10 clk = ~clk;
  assign rxd = lb ? txd : rx_drv;

  hsu_uart u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic stopb);
    @(negedge clk); rx_drv = 0;
    repeat (14) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_drv = d[i]; repeat (14) @(negedge clk); end
    rx_drv = stopb; repeat (14) @(negedge clk);
    rx_drv = 1; repeat (28) @(negedge clk);
  endtask

  // behavioural transmit-line model
  logic [7:0] q[$];
  logic [9:0] fr;
  int left = 0, per_m = 1, m_rate = 255;
  logic m_brk = 0, full;
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); left = 0; m_rate = 255; m_brk = 0;
    end else begin
      full = q.size() >= 64;
      if (left > 0) left--;
      else if (q.size() > 0) begin
        fr = {1'b1, q.pop_front(), 1'b0};
        per_m = (m_rate + 1) * 14;
        left = 10 * per_m;
      end
      if (bus_wr && bus_addr == 5'h00 && !full) q.push_back(bus_wdata[7:0]);
      if (bus_wr && bus_addr == 5'h10) m_rate = int'(bus_wdata[7:0]);
      if (bus_wr && bus_addr == 5'h0C) m_brk = bus_wdata[8];
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic e;
    e = m_brk ? 1'b0 : (left > 0 ? fr[(10 * per_m - left) / per_m] : 1'b1);
    chk(m_brk ? "R13 txd" : "R2 txd", {31'd0, txd}, {31'd0, e});
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(5'h10, v); chk("R1 rate", v, 32'hFF);
    rd(5'h0C, v); chk("R1 ctrl", v, 0);
    rd(5'h04, v); chk("R1 level", v, 0);
    rd(5'h08, v); chk("R1 status", v, 0);
    rd(5'h00, v); chk("R1 data", v, 32'h100);
    chk("R1 irq", {31'd0, irq}, 0);

    // loopback transfer
    wr(5'h10, 0);
    wr(5'h0C, 32'h10009);
    lb = 1;
    wr(5'h00, 32'h55); wr(5'h00, 32'hA3); wr(5'h00, 32'h0F);
    repeat (3 * 141 + 60) @(negedge clk);
    rd(5'h04, v); chk("R4 level", v, 32'h3);
    rd(5'h08, v); chk("R9 tx request only", v, 32'h1);
    rd(5'h00, v); chk("R4 data0", v, 32'h55);
    rd(5'h00, v); chk("R4 data1", v, 32'hA3);
    rd(5'h00, v); chk("R4 data2", v, 32'h0F);
    rd(5'h00, v); chk("R4 empty", v, 32'h100);
    wr(5'h08, 32'h3F);
    rd(5'h08, v); chk("R11 cleared", v, 0);

    // R10 timeout of 4 character times
    wr(5'h00, 32'h5A);
    repeat (541) @(negedge clk);
    rd(5'h08, v); chk("R10 early", v & 32'h4, 0);
    chk("R12 rx group off", {31'd0, irq}, 0);
    repeat (300) @(negedge clk);
    rd(5'h08, v); chk("R10 fired", v & 32'h4, 32'h4);
    wr(5'h0C, 32'h10049);
    chk("R12 rx group on", {31'd0, irq}, 1);
    rd(5'h00, v); chk("R4 data3", v, 32'h5A);
    wr(5'h08, 32'h3F);
    lb = 0;

    // R8 trigger of 4
    wr(5'h0C, 32'h4);
    send(8'h11, 1); send(8'h22, 1); send(8'h33, 1);
    rd(5'h08, v); chk("R8 below level", v & 32'h2, 0);
    send(8'h44, 1);
    rd(5'h08, v); chk("R8 at level", v & 32'h2, 32'h2);
    rd(5'h04, v); chk("R4 rx level", v, 32'h4);
    rd(5'h00, v); chk("R4 driven data", v, 32'h11);
    for (int i = 0; i < 3; i++) rd(5'h00, v);

    // R5 / R6 framing and break
    wr(5'h08, 32'h3F);
    send(8'h3C, 0);
    rd(5'h00, v); chk("R5 word", v, 32'h23C);
    rd(5'h08, v); chk("R5 status", v & 32'h18, 32'h08);
    send(8'h00, 0);
    rd(5'h00, v); chk("R6 word", v, 32'h600);
    rd(5'h08, v); chk("R6 status", v & 32'h10, 32'h10);
    chk("R12 err group off", {31'd0, irq}, 0);
    wr(5'h0C, 32'h80);
    chk("R12 err group on", {31'd0, irq}, 1);
    wr(5'h08, 32'h08);
    rd(5'h08, v); chk("R11 single bit", v & 32'h18, 32'h10);
    wr(5'h08, 32'h10);
    chk("R12 err cleared", {31'd0, irq}, 0);
    wr(5'h08, 32'h40);
    rd(5'h08, v); chk("R9 software set", v, 32'h01);
    wr(5'h0C, 32'h20);
    chk("R12 tx group", {31'd0, irq}, 1);
    wr(5'h08, 32'h01);
    chk("R11 tx cleared", {31'd0, irq}, 0);

    // R13 forced break
    wr(5'h0C, 32'h100);
    repeat (20) @(negedge clk);
    chk("R13 held low", {31'd0, txd}, 0);
    wr(5'h0C, 0);
    #1 chk("R13 released", {31'd0, txd}, 1);

    // R3 / R7 fill and overrun in loopback
    lb = 1;
    wr(5'h08, 32'h3F);
    wr(5'h0C, 32'h29);
    for (int i = 0; i < 70; i++) wr(5'h00, i);
    rd(5'h04, v); chk("R3 tx full", (v >> 8) & 32'hFF, 64);
    repeat (65 * 141 + 300) @(negedge clk);
    rd(5'h04, v); chk("R7 level", v, 32'h40);
    rd(5'h08, v); chk("R7 R8 R9 status", v & 32'h23, 32'h23);
    chk("R12 irq", {31'd0, irq}, 1);
    for (int i = 0; i < 64; i++) begin
      rd(5'h00, v); chk("R3 order", v, i);
    end
    rd(5'h00, v); chk("R7 dropped", v, 32'h100);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule